// File: doc/BRIEF.md
# Indirect Auto-Increment Memory Window

An 8-bit host reaches a 32 KB internal byte space through four byte registers. One register holds mode bits. Two registers hold the high and low bytes of an internal pointer. The fourth is a data port. Each data-port access moves one byte at the pointer. When post-increment is enabled, the pointer then advances, so the host can stream a block of bytes after loading the address once. The internal space is split into a configuration area from 0x0000, per-channel blocks at 0x0400 + 0x100·n, a transmit area at 0x4000 and a receive area at 0x6000. Each channel owns a 2 KB segment in both buffer areas.

The block adds an optional segment-ring mode for the buffer areas. In this mode the pointer wraps inside its 2 KB segment, so a driver that walks a channel's buffer does not have to mask and rebase the address itself. A mode write with bit 7 set performs a soft reset. The backing store is a small RAM that repeats across the whole pointer space (it is decoded by the low `RAM_AW` pointer bits). It stands in for the real register and buffer memory.

Host accesses are single-cycle strobes. A read returns its byte on `rdata_o` after the clock edge that samples the strobe, and that byte holds until the next accepted read.

Top module: `indirect_window`

## Requirements
- R1: After `rst_ni` is asserted, the mode register (offset 0) and both pointer bytes (offsets 1 and 2) read 0x00.
- R2: Writing offset 2 loads pointer bits [7:0]. Writing offset 1 loads pointer bits [14:8] from data bits [6:0]. Neither write disturbs the other byte. Offset 1 reads back with bit 7 = 0.
- R3: Only mode bits 0 (window enable), 1 (post-increment) and 4 (segment ring) are stored. All other mode bits read 0.
- R4: With mode bit 0 set, a data-port (offset 3) write stores its byte at the RAM cell selected by the low `RAM_AW` pointer bits, and a data-port read returns that cell.
- R5: With mode bits 0 and 1 set, every data-port access advances the pointer by one after the access. With bit 1 clear, the pointer is left unchanged.
- R6: A post-increment from a low byte of 0xFF carries into the high byte. A post-increment from 0x7FFF gives 0x0000 when ring mode is off.
- R7: With mode bit 4 set and the pointer at or above 0x4000, a post-increment changes only pointer bits [10:0]. For example, 0x67FF steps to 0x6000. Below 0x4000, the step is a plain increment.
- R8: With mode bit 0 clear, data-port writes leave the RAM unchanged, data-port reads return 0x00, and the pointer does not move.
- R9: A mode write with bit 7 set clears the mode and the pointer. The block ignores every access in the following cycle, and after that the mode, pointer high and pointer low all read 0x00.
- R10: `rdata_o` changes only at the edge that samples an accepted read, and it holds through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Access strobe, one access per cycle it is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Window offset: 0 mode, 1 pointer high, 2 pointer low, 3 data |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, registered |

## Verification
The bench sweeps every mode value without bit 7 and every value of each pointer byte, then fills the whole RAM through the streaming port and reads it back. This would expose a design that keeps reserved bits, corrupts the neighbouring byte, or drops or repeats a byte while streaming. It then aims at the pointer boundaries: the carry from 0x00FF, the wrap at 0x7FFF, and the segment edges at 0x47FF, 0x67FF and 0x7FFF in ring mode, plus the step from 0x3FFF, which must leave the segment. A carry bug, or a ring applied below the buffer base, would land the next byte at the wrong address. Further checks confirm that a disabled window writes nothing and does not step. They also confirm that the cycle after a soft reset swallows a pointer write, and that the read register holds through writes, which would catch a read path that tracks the pointer live.

// File: rtl/indwin_pkg.sv
package indwin_pkg;
  typedef enum logic [1:0] {
    OFS_MODE   = 2'd0,
    OFS_PTR_HI = 2'd1,
    OFS_PTR_LO = 2'd2,
    OFS_DATA   = 2'd3
  } win_ofs_e;

  localparam int MB_EN   = 0;
  localparam int MB_AINC = 1;
  localparam int MB_RING = 4;
  localparam int MB_SRST = 7;

  localparam logic [7:0] MODE_KEEP = 8'h13;
  localparam logic [7:0] MODE_SRST = 8'h80;
endpackage

// File: rtl/indwin_mode.sv
module indwin_mode
  import indwin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] mode_o
);
  logic [7:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mode_q <= '0;
    else if (mode_q[MB_SRST]) mode_q <= '0;
    else if (wr_i) begin
      if (wdata_i[MB_SRST]) mode_q <= MODE_SRST;
      else                  mode_q <= wdata_i & MODE_KEEP;
    end
  end

  assign mode_o = mode_q;

  p_srst_self_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[MB_SRST] |=> !mode_q[MB_SRST]);
  p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !mode_q[MB_SRST]) |=> $stable(mode_q));
endmodule

// File: rtl/indwin_ptr.sv
module indwin_ptr #(
  parameter int ADDR_W   = 15,
  parameter int SEG_W    = 11,
  parameter int BUF_BASE = 'h4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        wdata_i,
  input  logic              step_i,
  input  logic              ring_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] BUF_A = ADDR_W'(BUF_BASE);

  logic [ADDR_W-1:0] ptr_q, inc_full, inc_seg, ptr_nxt;
  logic              ring_hit;

  always_comb begin
    ring_hit = ring_i && (ptr_q >= BUF_A);
    inc_full = ptr_q + ADDR_W'(1);
    inc_seg  = {ptr_q[ADDR_W-1:SEG_W], ptr_q[SEG_W-1:0] + SEG_W'(1)};
    ptr_nxt  = ring_hit ? inc_seg : inc_full;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (ld_hi_i) ptr_q[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
    else if (ld_lo_i) ptr_q[7:0] <= wdata_i;
    else if (step_i)  ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;

  p_hold_no_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_hi_i && !ld_lo_i && !step_i) |=> $stable(ptr_q));
  p_ring_keeps_seg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !ld_hi_i && !ld_lo_i && ring_i && ptr_q >= BUF_A)
      |=> ptr_q[ADDR_W-1:SEG_W] == $past(ptr_q[ADDR_W-1:SEG_W]));
  p_lo_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !ld_hi_i && !ld_lo_i && !ring_i && ptr_q[7:0] == 8'hFF)
      |=> ptr_q[7:0] == 8'h00 && ptr_q[ADDR_W-1:8] == $past(ptr_q[ADDR_W-1:8]) + HI_W'(1));
endmodule

// File: rtl/indwin_ram.sv
module indwin_ram #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/indirect_window.sv
module indirect_window
  import indwin_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int RAM_AW   = 10,
  parameter int SEG_W    = 11,
  parameter int BUF_BASE = 'h4000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  win_ofs_e          ofs;
  logic [7:0]        mode;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        ram_q, rdata_q;
  logic              acc_ok, en, data_hit, mode_wr, srst, ld_hi, ld_lo, step, rd_ok;

  always_comb begin
    ofs      = win_ofs_e'(addr_i);
    acc_ok   = acc_i && !mode[MB_SRST];  // cycle after soft reset swallows access
    en       = mode[MB_EN];
    data_hit = acc_ok && ofs == OFS_DATA && en;
    mode_wr  = acc_ok && wr_i && ofs == OFS_MODE;
    srst     = mode_wr && wdata_i[MB_SRST];
    ld_hi    = acc_ok && wr_i && ofs == OFS_PTR_HI;
    ld_lo    = acc_ok && wr_i && ofs == OFS_PTR_LO;
    step     = data_hit && mode[MB_AINC];
    rd_ok    = acc_ok && !wr_i;
  end

  indwin_mode u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mode_wr),
    .wdata_i (wdata_i),
    .mode_o  (mode)
  );

  indwin_ptr #(
    .ADDR_W   (ADDR_W),
    .SEG_W    (SEG_W),
    .BUF_BASE (BUF_BASE)
  ) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst),
    .ld_hi_i (ld_hi),
    .ld_lo_i (ld_lo),
    .wdata_i (wdata_i),
    .step_i  (step),
    .ring_i  (mode[MB_RING]),
    .ptr_o   (ptr)
  );

  indwin_ram #(.AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (data_hit && wr_i),
    .addr_i  (ptr[RAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_ok) begin
      unique case (ofs)
        OFS_MODE:   rdata_q <= mode;
        OFS_PTR_HI: rdata_q <= 8'(ptr[ADDR_W-1:8]);
        OFS_PTR_LO: rdata_q <= ptr[7:0];
        OFS_DATA:   rdata_q <= en ? ram_q : 8'h00;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  p_srst_ptr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode[MB_SRST] |-> ptr == '0);
  p_off_no_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !mode[MB_SRST] && !mode[MB_EN] && addr_i == 2'd3) |=> $stable(ptr));
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && !wr_i && !mode[MB_SRST]) |=> $stable(rdata_o));
endmodule

// File: tb/indirect_window_tb_top.sv
module indirect_window_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_mode = 0, m_ptr = 0;
  int mem [1024];

  always #5 clk = ~clk;

  indirect_window dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int nxt(input int p);
    if ((m_mode & 'h10) != 0 && p >= 'h4000) return (p & ~'h7FF) | ((p + 1) & 'h7FF);
    return (p + 1) & 'h7FFF;
  endfunction

  task automatic access(input logic w, input logic [1:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    acc = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    q = rdata;
    acc = 1'b0;
  endtask

  task automatic wrm(input logic [1:0] a, input int d);
    logic [7:0] q;
    access(1'b1, a, 8'(d), q);
    case (a)
      2'd0: m_mode = d & 'h13;
      2'd1: m_ptr = ((d & 'h7F) << 8) | (m_ptr & 'hFF);
      2'd2: m_ptr = (m_ptr & 'h7F00) | (d & 'hFF);
      default: if ((m_mode & 1) != 0) begin
        mem[m_ptr & 'h3FF] = d & 'hFF;
        if ((m_mode & 2) != 0) m_ptr = nxt(m_ptr);
      end
    endcase
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    logic [7:0] q;
    int exp;
    case (a)
      2'd0: exp = m_mode;
      2'd1: exp = m_ptr >> 8;
      2'd2: exp = m_ptr & 'hFF;
      default: exp = ((m_mode & 1) != 0) ? mem[m_ptr & 'h3FF] : 0;
    endcase
    access(1'b0, a, 8'h00, q);
    if (a == 2'd3 && (m_mode & 3) == 3) m_ptr = nxt(m_ptr);
    chk(req, int'(q), exp);
  endtask

  task automatic set_ptr(input int p);
    wrm(2'd1, p >> 8);
    wrm(2'd2, p & 'hFF);
  endtask

  task automatic chk_ptr(input string req, input int exp);
    chk(req, m_ptr, exp);
    rd(req, 2'd1);
    rd(req, 2'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q, held;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2);
    rd("R8 off read", 2'd3);

    // R3 sweep of mode values without bit 7
    for (int v = 0; v < 128; v++) begin
      wrm(2'd0, v);
      rd("R3", 2'd0);
    end
    wrm(2'd0, 0);

    // R2 pointer byte sweeps
    wrm(2'd1, 'h2A);
    for (int v = 0; v < 256; v++) begin
      wrm(2'd2, v);
      rd("R2 lo", 2'd2);
      rd("R2 hi kept", 2'd1);
    end
    for (int v = 0; v < 256; v++) begin
      wrm(2'd1, v);
      rd("R2 hi bit7=0", 2'd1);
    end
    rd("R2 lo kept", 2'd2);

    // R4/R5 stream-fill the whole RAM then read back
    wrm(2'd0, 'h03);
    set_ptr(0);
    for (int i = 0; i < 1024; i++) wrm(2'd3, (i * 7 + 3) & 'hFF);
    chk_ptr("R5 ptr after fill", 'h0400);
    set_ptr(0);
    for (int i = 0; i < 1024; i++) rd("R4 readback", 2'd3);
    set_ptr('h2005);
    rd("R4 alias", 2'd3);

    // R5 without post-increment
    wrm(2'd0, 'h01);
    set_ptr('h0123);
    wrm(2'd3, 'hAA);
    wrm(2'd3, 'hAB);
    rd("R5 no step", 2'd3);
    chk_ptr("R5 ptr held", 'h0123);

    // R6 carry and top wrap
    wrm(2'd0, 'h03);
    set_ptr('h00FF);
    wrm(2'd3, 'h11);
    chk_ptr("R6 carry", 'h0100);
    set_ptr('h7FFF);
    rd("R6 top", 2'd3);
    chk_ptr("R6 wrap", 'h0000);

    // R7 segment ring
    wrm(2'd0, 'h13);
    set_ptr('h67FF);
    rd("R7", 2'd3);
    chk_ptr("R7 67FF", 'h6000);
    set_ptr('h47FE);
    wrm(2'd3, 'h21);
    wrm(2'd3, 'h22);
    chk_ptr("R7 47FF", 'h4000);
    set_ptr('h7FFF);
    rd("R7", 2'd3);
    chk_ptr("R7 7FFF", 'h7800);
    set_ptr('h3FFF);
    rd("R7 below base", 2'd3);
    chk_ptr("R7 below base", 'h4000);

    // R8 window disabled
    wrm(2'd0, 'h02);
    set_ptr('h0010);
    wrm(2'd3, 'h5A);
    rd("R8 off read", 2'd3);
    chk_ptr("R8 no step", 'h0010);
    wrm(2'd0, 'h01);
    rd("R8 ram untouched", 2'd3);

    // R9 soft reset
    wrm(2'd0, 'h03);
    set_ptr('h1234);
    access(1'b1, 2'd0, 8'h83, q);
    access(1'b1, 2'd2, 8'h55, q);
    m_mode = 0; m_ptr = 0;
    rd("R9 mode", 2'd0);
    rd("R9 hi", 2'd1);
    rd("R9 lo", 2'd2);

    // R10 read register holds through writes and idle
    set_ptr('h0177);
    rd("R10", 2'd2);
    held = 8'h77;
    wrm(2'd2, 'h01);
    wrm(2'd0, 'h03);
    wrm(2'd3, 'hEE);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 hold", int'(rdata), int'(held));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule